// File: doc/BRIEF.md
# Windowed Integer Register File

This block is an integer register file whose 32 architectural register numbers map onto a larger physical array through a current-window pointer. Eight global registers map to fixed storage. The other 24 numbers select the outs, locals and ins of the current window. Next to each other, windows share storage physically: the outs of one window are the ins of the window one step deeper. On a procedure call, the caller's outgoing arguments therefore appear as the callee's incoming arguments without any copy.

A save request moves the pointer one window deeper and a restore moves it back. The block counts the windows that hold live state. When a save would reach a window that is still in use, the block rejects it and raises a one-cycle overflow flag. When a restore would go past the oldest live window, it rejects it and raises a one-cycle underflow flag. Surrounding logic spills and fills windows from these flags. The block has two combinational read ports and one write port. The window count is a parameter, and the physical storage holds 8 + 16*NWIN registers, which must not exceed 160.

Top module: `rf_win`

## Requirements
- R1: After reset, cwp_o is 0, live_o is 1, ovf_o and unf_o are low, and every register reads zero.
- R2: Register numbers 0-7 select globals (1-7 writable), 8-15 outs, 16-23 locals and 24-31 ins. A global reads the same value whatever the window.
- R3: Register number 0 always reads zero, and writes to it have no effect.
- R4: The locals (16-23) of each window are private storage that no other window can reach.
- R5: The outs (8-15) of window w are the same storage as the ins (24-31) of window (w-1) mod NWIN. This includes the wrap where the outs of window 0 are the ins of window NWIN-1.
- R6: An accepted save sets cwp_o to (cwp_o-1) mod NWIN and increments live_o. An accepted restore sets cwp_o to (cwp_o+1) mod NWIN and decrements live_o. live_o stays within 1..NWIN-1.
- R7: A save issued while live_o equals NWIN-1 leaves cwp_o and live_o unchanged and drives ovf_o high for exactly the following cycle.
- R8: A restore issued while live_o equals 1 leaves cwp_o and live_o unchanged and drives unf_o high for exactly the following cycle.
- R9: A write issued in the same cycle as a save or restore lands in the window selected by the pointer from before the move.
- R10: Asserting save and restore together moves nothing and raises no flag.
- R11: Both read ports return their registers in the same cycle, combinationally, and independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs_a_i | input | 5 | Register number for read port A |
| rd_a_o | output | XLEN | Read data for port A |
| rs_b_i | input | 5 | Register number for read port B |
| rd_b_o | output | XLEN | Read data for port B |
| we_i | input | 1 | Write enable |
| wr_reg_i | input | 5 | Register number to write |
| wdata_i | input | XLEN | Write data |
| save_i | input | 1 | Move one window deeper |
| restore_i | input | 1 | Move one window back |
| cwp_o | output | CW | Current window pointer |
| live_o | output | LW | Count of windows holding live state |
| ovf_o | output | 1 | Rejected save, one-cycle pulse |
| unf_o | output | 1 | Rejected restore, one-cycle pulse |

## Verification
The bench builds the block with NWIN=4, which gives 72 physical registers and allows at most three live windows. With this configuration, every pointer position, both wraps of the pointer and both the overflow and underflow limits are reached within a few operations. After every operation the bench sweeps all 32 register numbers on both ports against an arithmetic model of the physical array. This covers the shared in/out aliasing and the aliasing from window 0 to the last window, with writes landing during saves and restores.

// File: rtl/rf_win_pkg.sv
`timescale 1ns/1ps
package rf_win_pkg;
  localparam int unsigned GRP_SZ  = 8;
  localparam int unsigned WIN_SZ  = 16;
  localparam int unsigned MAX_PHY = 160;

  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } grp_e;

  function automatic grp_e grp_of(input logic [4:0] r);
    return grp_e'(r[4:3]);
  endfunction
endpackage

// File: rtl/rf_win_map.sv
`timescale 1ns/1ps
module rf_win_map
  import rf_win_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3,
  parameter int unsigned PW   = 8
) (
  input  logic [CW-1:0] cwp_i,
  input  logic [4:0]    reg_i,
  output logic [PW-1:0] idx_o
);
  int unsigned cur_w, prv_w, off, idx;

  always_comb begin
    cur_w = int'(cwp_i);
    // outs of this window live in the ins slot of the next deeper window
    prv_w = (cur_w == 0) ? NWIN - 1 : cur_w - 1;
    off   = int'(reg_i[2:0]);
    unique case (grp_of(reg_i))
      GRP_GLB: idx = off;
      GRP_LOC: idx = GRP_SZ + WIN_SZ * cur_w + off;
      GRP_IN:  idx = GRP_SZ + WIN_SZ * cur_w + GRP_SZ + off;
      GRP_OUT: idx = GRP_SZ + WIN_SZ * prv_w + GRP_SZ + off;
      default: idx = 0;
    endcase
    idx_o = idx[PW-1:0];
  end
endmodule

// File: rtl/rf_win_ctrl.sv
`timescale 1ns/1ps
module rf_win_ctrl #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3,
  parameter int unsigned LW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          save_i,
  input  logic          restore_i,
  output logic [CW-1:0] cwp_o,
  output logic [LW-1:0] live_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [CW-1:0] CWP_TOP  = CW'(NWIN - 1);
  localparam logic [LW-1:0] LIVE_MAX = LW'(NWIN - 1);
  localparam logic [LW-1:0] LIVE_MIN = LW'(1);

  logic save_only, rest_only, can_save, can_rest;
  logic [CW-1:0] cwp_dn, cwp_up;

  assign save_only = save_i & ~restore_i;
  assign rest_only = restore_i & ~save_i;
  assign can_save  = live_o < LIVE_MAX;
  assign can_rest  = live_o > LIVE_MIN;
  assign cwp_dn    = (cwp_o == '0) ? CWP_TOP : cwp_o - CW'(1);
  assign cwp_up    = (cwp_o == CWP_TOP) ? '0 : cwp_o + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_o  <= '0;
      live_o <= LIVE_MIN;
      ovf_o  <= 1'b0;
      unf_o  <= 1'b0;
    end else begin
      ovf_o <= save_only & ~can_save;
      unf_o <= rest_only & ~can_rest;
      if (save_only && can_save) begin
        cwp_o  <= cwp_dn;
        live_o <= live_o + LW'(1);
      end else if (rest_only && can_rest) begin
        cwp_o  <= cwp_up;
        live_o <= live_o - LW'(1);
      end
    end
  end
endmodule

// File: rtl/rf_win_store.sv
`timescale 1ns/1ps
module rf_win_store #(
  parameter int unsigned NPHY = 136,
  parameter int unsigned PW   = 8,
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PW-1:0]   widx_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [PW-1:0]   ridx_a_i,
  input  logic [PW-1:0]   ridx_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] mem [NPHY];

  // entry 0 is the hardwired zero global
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NPHY); i++) mem[i] <= '0;
    end else if (we_i && widx_i != '0) begin
      mem[widx_i] <= wdata_i;
    end
  end

  assign rdata_a_o = (ridx_a_i == '0) ? '0 : mem[ridx_a_i];
  assign rdata_b_o = (ridx_b_i == '0) ? '0 : mem[ridx_b_i];
endmodule

// File: rtl/rf_win.sv
`timescale 1ns/1ps
module rf_win
  import rf_win_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  localparam int unsigned NPHY = GRP_SZ + WIN_SZ * NWIN,
  localparam int unsigned PW   = $clog2(NPHY),
  localparam int unsigned CW   = (NWIN > 2) ? $clog2(NWIN) : 1,
  localparam int unsigned LW   = $clog2(NWIN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      rs_a_i,
  output logic [XLEN-1:0] rd_a_o,
  input  logic [4:0]      rs_b_i,
  output logic [XLEN-1:0] rd_b_o,
  input  logic            we_i,
  input  logic [4:0]      wr_reg_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            save_i,
  input  logic            restore_i,
  output logic [CW-1:0]   cwp_o,
  output logic [LW-1:0]   live_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic [4:0]    reg_sel [3];
  logic [PW-1:0] phy_idx [3];

  assign reg_sel[0] = rs_a_i;
  assign reg_sel[1] = rs_b_i;
  assign reg_sel[2] = wr_reg_i;

  rf_win_ctrl #(.NWIN(NWIN), .CW(CW), .LW(LW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .save_i   (save_i),
    .restore_i(restore_i),
    .cwp_o    (cwp_o),
    .live_o   (live_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
  );

  // write maps through the pre-move pointer since cwp_o is registered
  for (genvar p = 0; p < 3; p++) begin : g_map
    rf_win_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
      .cwp_i(cwp_o),
      .reg_i(reg_sel[p]),
      .idx_o(phy_idx[p])
    );
  end

  rf_win_store #(.NPHY(NPHY), .PW(PW), .XLEN(XLEN)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .widx_i   (phy_idx[2]),
    .wdata_i  (wdata_i),
    .ridx_a_i (phy_idx[0]),
    .ridx_b_i (phy_idx[1]),
    .rdata_a_o(rd_a_o),
    .rdata_b_o(rd_b_o)
  );
endmodule

// File: rtl/rf_win_chk.sv
`timescale 1ns/1ps
module rf_win_chk #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  parameter int unsigned CW   = 3,
  parameter int unsigned LW   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [4:0]      rs_a_i,
  input logic [XLEN-1:0] rd_a_o,
  input logic [4:0]      rs_b_i,
  input logic [XLEN-1:0] rd_b_o,
  input logic            we_i,
  input logic [4:0]      wr_reg_i,
  input logic [XLEN-1:0] wdata_i,
  input logic            save_i,
  input logic            restore_i,
  input logic [CW-1:0]   cwp_o,
  input logic [LW-1:0]   live_o,
  input logic            ovf_o,
  input logic            unf_o
);
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  a_r3_g0_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_a_i == 5'd0 |-> rd_a_o == '0);
  a_r3_g0_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_b_i == 5'd0 |-> rd_b_o == '0);
  a_r6_live_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o >= LW'(1) && live_o <= LW'(NWIN - 1));
  a_r6_save_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i && !restore_i |=> ovf_o ||
      cwp_o == (($past(cwp_o) == '0) ? TOP : $past(cwp_o) - CW'(1)));
  a_r6_restore_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && !save_i |=> unf_o ||
      cwp_o == (($past(cwp_o) == TOP) ? '0 : $past(cwp_o) + CW'(1)));
  a_r7_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $stable(cwp_o) && $stable(live_o));
  a_r8_unf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> $stable(cwp_o) && $stable(live_o));
  a_r10_both_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i && restore_i |=> !ovf_o && !unf_o && $stable(cwp_o));
  a_r9_write_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wr_reg_i != 5'd0 && !save_i && !restore_i |=>
      rs_a_i != $past(wr_reg_i) || rd_a_o == $past(wdata_i));
endmodule

bind rf_win rf_win_chk #(.NWIN(NWIN), .XLEN(XLEN), .CW(CW), .LW(LW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rs_a_i(rs_a_i), .rd_a_o(rd_a_o),
  .rs_b_i(rs_b_i), .rd_b_o(rd_b_o), .we_i(we_i), .wr_reg_i(wr_reg_i),
  .wdata_i(wdata_i), .save_i(save_i), .restore_i(restore_i),
  .cwp_o(cwp_o), .live_o(live_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/rf_win_bench.sv
`timescale 1ns/1ps
module rf_win_bench;
  localparam int NWIN = 4;
  localparam int XLEN = 32;
  localparam int NPHY = 8 + 16 * NWIN;
  localparam int CW   = 2;
  localparam int LW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] rs_a = '0, rs_b = '0, wr_reg = '0;
  logic [XLEN-1:0] rd_a, rd_b, wdata = '0;
  logic we = 1'b0, sv = 1'b0, rs = 1'b0;
  logic [CW-1:0] cwp;
  logic [LW-1:0] live;
  logic ovf, unf;

  int errors = 0;
  int checks = 0;
  logic [XLEN-1:0] mdl [NPHY];
  int m_cwp = 0;
  int m_live = 1;

  always #10 clk = ~clk;

  rf_win #(.NWIN(NWIN), .XLEN(XLEN)) u_rf_win (
    .clk_i(clk), .rst_ni(rst_n), .rs_a_i(rs_a), .rd_a_o(rd_a),
    .rs_b_i(rs_b), .rd_b_o(rd_b), .we_i(we), .wr_reg_i(wr_reg),
    .wdata_i(wdata), .save_i(sv), .restore_i(rs), .cwp_o(cwp),
    .live_o(live), .ovf_o(ovf), .unf_o(unf)
  );

  function automatic int phys(int w, int r);
    if (r < 8)  return r;
    if (r < 16) return 8 + 16 * ((w + NWIN - 1) % NWIN) + 8 + (r - 8);
    if (r < 24) return 8 + 16 * w + (r - 16);
    return 8 + 16 * w + 8 + (r - 24);
  endfunction

  function automatic string tag_of(int r);
    if (r == 0) return "R3";
    if (r < 8)  return "R2";
    if (r < 16) return "R5";
    if (r < 24) return "R4";
    return "R5";
  endfunction

  task automatic chk(logic [XLEN-1:0] act, logic [XLEN-1:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] exp_rd(int r);
    return (r == 0) ? '0 : mdl[phys(m_cwp, r)];
  endfunction

  task automatic sweep();
    for (int r = 0; r < 32; r++) begin
      rs_a = 5'(r);
      rs_b = 5'(31 - r);
      #0.25;
      chk(rd_a, exp_rd(r), tag_of(r));
      chk(rd_b, exp_rd(31 - r), "R11");
    end
  endtask

  task automatic op(bit s, bit r, bit w, int wr, logic [XLEN-1:0] wd);
    bit e_ovf, e_unf;
    @(negedge clk);
    sv = s; rs = r; we = w; wr_reg = 5'(wr); wdata = wd;
    @(posedge clk);
    if (w && wr != 0) mdl[phys(m_cwp, wr)] = wd;
    e_ovf = s && !r && m_live == NWIN - 1;
    e_unf = r && !s && m_live == 1;
    if (s && !r && !e_ovf) begin m_cwp = (m_cwp + NWIN - 1) % NWIN; m_live++; end
    if (r && !s && !e_unf) begin m_cwp = (m_cwp + 1) % NWIN; m_live--; end
    #2;
    sv = 1'b0; rs = 1'b0; we = 1'b0;
    chk(XLEN'(cwp), XLEN'(m_cwp), (s && r) ? "R10" : "R6");
    chk(XLEN'(live), XLEN'(m_live), "R6");
    chk(XLEN'(ovf), XLEN'(e_ovf), (s && r) ? "R10" : "R7");
    chk(XLEN'(unf), XLEN'(e_unf), (s && r) ? "R10" : "R8");
    sweep();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPHY; i++) mdl[i] = '0;
    #35;
    // R1: reset state
    chk(XLEN'(cwp), 0, "R1");
    chk(XLEN'(live), 1, "R1");
    chk(XLEN'({ovf, unf}), 0, "R1");
    for (int r = 0; r < 32; r++) begin
      rs_a = 5'(r); #0.25; chk(rd_a, '0, "R1");
    end
    rst_n = 1'b1;

    // R8: restore at the oldest window
    op(0, 1, 0, 0, '0);
    // R3: write to register 0 is dropped
    op(0, 0, 1, 0, 32'hDEAD_BEEF);
    // fill window 0
    for (int r = 1; r < 32; r++) op(0, 0, 1, r, 32'h1000_0000 + 32'(r));
    // R9: write lands in the pre-save window, then read it back after restore
    op(1, 0, 1, 16, 32'h0000_CAFE);
    op(0, 1, 0, 0, '0);
    rs_a = 5'd16; #0.25; chk(rd_a, 32'h0000_CAFE, "R9");
    op(0, 1, 1, 9, 32'h0000_BEEF); // restore rejected, write still lands
    // R5 wrap: outs of window 0 become ins of window NWIN-1
    op(0, 0, 1, 12, 32'h0000_0A11);
    op(1, 0, 0, 0, '0);
    rs_a = 5'd28; #0.25; chk(rd_a, 32'h0000_0A11, "R5");
    // R7: fill to the limit and overflow
    op(1, 0, 0, 0, '0);
    op(1, 0, 0, 0, '0);
    op(1, 0, 0, 0, '0);
    // R10: both together
    op(1, 1, 1, 20, 32'h0000_5151);
    // randomized traffic with model comparison after each cycle
    for (int n = 0; n < 600; n++) begin
      int k;
      k = int'($urandom % 8);
      op(k < 2 || k == 4, (k == 2 || k == 3 || k == 4), ($urandom % 2) == 1,
         int'($urandom % 32), $urandom);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule